// File: doc/BRIEF.md
# Backend Reset Qualifier and Stretcher

This block turns an active-low reset request from the host, together with an internal undervoltage reset request, into a complementary pair of local reset outputs for the card's backend logic. The host input is first brought into the system clock domain. It is then qualified: a low level counts only once it has lasted longer than a configurable glitch window, which is measured in system clocks.

A qualified host reset starts a stretch window that is counted in ticks of an external microsecond strobe. While the window runs, or while the host keeps its request low, both outputs stay asserted. The outputs are also asserted for as long as the undervoltage request is present. They are asserted from power-on reset until the first stretch window has finished. A new qualified assertion during a running window starts the window again from zero.

Top module: `bkend_rst_ctrl`

## Requirements
- R1: A low pulse on `host_rst_n` that is sampled low on no more than GLITCH_NS*CLK_MHZ/1000 consecutive clock edges has no effect. This is 10 edges, or 40 ns, at the default 250 MHz. Both outputs stay inactive, where inactive means `lrst_n`=1 and `lrst`=0.
- R2: A low level sampled on GLITCH_NS*CLK_MHZ/1000+1 consecutive edges (11 by default) qualifies. Both outputs become active (`lrst_n`=0, `lrst`=1) within 20 clock cycles of the first low sample, which is well inside 1 µs.
- R3: After a qualified assertion, both outputs stay active for at least HOLD_US ticks of `us_tick`. If the host input has returned high by then, they go inactive when the window ends.
- R4: If `host_rst_n` is still low when the window ends, the outputs stay active until it goes high. They go inactive no more than 5 cycles after the host input rises.
- R5: `lrst` is always the complement of `lrst_n`.
- R6: A high level on `uv_req` makes both outputs active on the next clock edge, whatever the stretch state. When `uv_req` falls outside any stretch window, the outputs go inactive on the following edge.
- R7: Both outputs are active while `rst_n` is low. After `rst_n` is released, they stay active until HOLD_US ticks have elapsed.
- R8: A new qualified host assertion during a running window restarts the window, so the outputs stay active for HOLD_US ticks counted from the newer assertion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| us_tick | input | 1 | One-cycle strobe, once per microsecond |
| host_rst_n | input | 1 | Host reset request, active low, asynchronous |
| uv_req | input | 1 | Internal undervoltage reset request, active high, synchronous |
| lrst_n | output | 1 | Local backend reset, active low |
| lrst | output | 1 | Local backend reset, active high |

## Verification
Two functions can act in the same cycle. The stretch window can expire while an undervoltage request is still present, and a host re-assertion can arrive while a window is still running. The bench provokes the first case by raising `uv_req` before the window's end and holding it well past that end. The outputs must then stay active until `uv_req` falls, not until the window ends. It provokes the second by qualifying a second host pulse partway through the first window, and then checks that the outputs are still active after the point where the first window alone would have released them.

// File: rtl/bkend_rst_pkg.sv
package bkend_rst_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_HOLD = 2'd1,
        ST_WAIT = 2'd2
    } hold_st_e;

    // Clock edges a low level must span to count as "longer than" the glitch window
    function automatic int filt_cycles(input int glitch_ns, input int clk_mhz);
        return (glitch_ns * clk_mhz) / 1000 + 1;
    endfunction

endpackage

// File: rtl/hrst_sync.sv
module hrst_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] sh_d, sh_q;

    generate
        if (STAGES == 1) begin : g_one
            always_comb sh_d = din;
        end else begin : g_chain
            always_comb sh_d = {sh_q[STAGES-2:0], din};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= {STAGES{RST_VAL}};
        else        sh_q <= sh_d;
    end

    assign dout = sh_q[STAGES-1];
endmodule

// File: rtl/hrst_glitch_filt.sv
module hrst_glitch_filt #(
    parameter int FILT_CYC = 11
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl_n,
    output logic qual
);
    localparam int CW = $clog2(FILT_CYC + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          qual;
    } filt_t;

    filt_t f_d, f_q;

    always_comb begin
        f_d = f_q;
        if (lvl_n) begin
            f_d.cnt = '0;
        end else if (f_q.cnt != CW'(FILT_CYC)) begin
            f_d.cnt = f_q.cnt + CW'(1);
        end
        f_d.qual = (f_d.cnt == CW'(FILT_CYC));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) f_q <= '{cnt: '0, qual: 1'b0};
        else        f_q <= f_d;
    end

    assign qual = f_q.qual;
endmodule

// File: rtl/hrst_hold_fsm.sv
module hrst_hold_fsm
    import bkend_rst_pkg::*;
#(
    parameter int HOLD_US = 150000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic us_tick,
    input  logic qual,
    input  logic uv_req,
    output logic rst_act
);
    localparam int TW = $clog2(HOLD_US + 1);
    localparam logic [TW-1:0] TMR_LAST = TW'(HOLD_US - 1);

    typedef struct packed {
        hold_st_e      st;
        logic [TW-1:0] tmr;
        logic          qual_prev;
        logic          act;
    } hold_t;

    hold_t h_d, h_q;
    logic  qual_edge;

    always_comb begin
        h_d           = h_q;
        h_d.qual_prev = qual;
        qual_edge     = qual & ~h_q.qual_prev;
        case (h_q.st)
            ST_IDLE: begin
                if (qual_edge) begin
                    h_d.st  = ST_HOLD;
                    h_d.tmr = '0;
                end
            end
            ST_HOLD: begin
                if (qual_edge) begin
                    h_d.tmr = '0;
                end else if (us_tick) begin
                    if (h_q.tmr == TMR_LAST) begin
                        h_d.tmr = '0;
                        h_d.st  = qual ? ST_WAIT : ST_IDLE;
                    end else begin
                        h_d.tmr = h_q.tmr + TW'(1);
                    end
                end
            end
            ST_WAIT: begin
                if (!qual) h_d.st = ST_IDLE;
            end
            default: begin
                h_d.st  = ST_HOLD;
                h_d.tmr = '0;
            end
        endcase
        h_d.act = (h_d.st != ST_IDLE) | uv_req;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) h_q <= '{st: ST_HOLD, tmr: '0, qual_prev: 1'b0, act: 1'b1};
        else        h_q <= h_d;
    end

    assign rst_act = h_q.act;
endmodule

// File: rtl/bkend_rst_ctrl.sv
module bkend_rst_ctrl #(
    parameter int CLK_MHZ     = 250,
    parameter int GLITCH_NS   = 40,
    parameter int HOLD_US     = 150000,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic us_tick,
    input  logic host_rst_n,
    input  logic uv_req,
    output logic lrst_n,
    output logic lrst
);
    localparam int FILT_CYC = bkend_rst_pkg::filt_cycles(GLITCH_NS, CLK_MHZ);

    logic host_sync_n;
    logic host_qual;
    logic rst_act;

    hrst_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (host_rst_n),
        .dout (host_sync_n)
    );

    hrst_glitch_filt #(.FILT_CYC(FILT_CYC)) u_filt (
        .clk  (clk),
        .rst_n(rst_n),
        .lvl_n(host_sync_n),
        .qual (host_qual)
    );

    hrst_hold_fsm #(.HOLD_US(HOLD_US)) u_hold (
        .clk    (clk),
        .rst_n  (rst_n),
        .us_tick(us_tick),
        .qual   (host_qual),
        .uv_req (uv_req),
        .rst_act(rst_act)
    );

    assign lrst   = rst_act;
    assign lrst_n = ~rst_act;
endmodule

// File: rtl/bkend_rst_chk.sv
module bkend_rst_chk #(
    parameter int HOLD_US = 150000
) (
    input logic clk,
    input logic rst_n,
    input logic us_tick,
    input logic uv_req,
    input logic host_qual,
    input logic lrst_n,
    input logic lrst
);
    localparam int TW = $clog2(HOLD_US + 1);

    logic [TW-1:0] ticks_q;
    logic          qual_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ticks_q <= '0;
            qual_q  <= 1'b0;
        end else begin
            qual_q <= host_qual;
            if (host_qual && !qual_q)                      ticks_q <= '0;
            else if (us_tick && ticks_q != TW'(HOLD_US))   ticks_q <= ticks_q + TW'(1);
        end
    end

    AST_PAIR_OPPOSED: assert property (@(posedge clk) disable iff (!rst_n)
        lrst != lrst_n); // R5

    AST_UV_FORCES: assert property (@(posedge clk) disable iff (!rst_n)
        uv_req |=> lrst); // R6

    AST_QUAL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        host_qual |=> lrst); // R4

    AST_MIN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(lrst) |-> (ticks_q >= TW'(HOLD_US - 1)) || $past(uv_req)); // R3
endmodule

bind bkend_rst_ctrl bkend_rst_chk #(.HOLD_US(HOLD_US)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .us_tick  (us_tick),
    .uv_req   (uv_req),
    .host_qual(host_qual),
    .lrst_n   (lrst_n),
    .lrst     (lrst)
);

// File: tb/bkend_rst_ctrl_test.sv
`timescale 1ns/1ps
module bkend_rst_ctrl_test;
    localparam int HOLD = 20;
    localparam int TDIV = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic us_tick = 1'b0;
    logic host_rst_n = 1'b1;
    logic uv_req = 1'b0;
    logic lrst_n, lrst;

    int cyc = 0;
    int checks = 0;
    int fails = 0;

    typedef struct {
        int    at;
        bit    act;
        string tag;
    } exp_t;
    exp_t sbq[$];
    exp_t it;

    bkend_rst_ctrl #(.CLK_MHZ(250), .GLITCH_NS(40), .HOLD_US(HOLD)) uut (
        .clk(clk), .rst_n(rst_n), .us_tick(us_tick),
        .host_rst_n(host_rst_n), .uv_req(uv_req),
        .lrst_n(lrst_n), .lrst(lrst)
    );

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;
    always @(negedge clk) us_tick <= (cyc % TDIV == TDIV - 1);

    // monitor: pops expectations when their cycle is reached
    always @(negedge clk) begin
        while (sbq.size() > 0 && sbq[0].at <= cyc) begin
            it = sbq.pop_front();
            checks++;
            if (lrst !== it.act || lrst_n !== !it.act) begin
                fails++;
                $display("FAIL %s cyc=%0d lrst=%b lrst_n=%b expected lrst=%b lrst_n=%b",
                         it.tag, cyc, lrst, lrst_n, it.act, !it.act);
            end
            checks++;
            if (lrst === lrst_n) begin
                fails++;
                $display("FAIL R5 cyc=%0d lrst=%b lrst_n=%b expected opposite levels",
                         cyc, lrst, lrst_n);
            end
        end
    end

    task automatic expect_at(input int dly, input bit act, input string tag);
        exp_t e;
        e.at = cyc + dly; e.act = act; e.tag = tag;
        sbq.push_back(e);
    endtask

    task automatic host_low(input int n);
        host_rst_n = 1'b0;
        repeat (n) @(negedge clk);
        host_rst_n = 1'b1;
    endtask

    task automatic drain;
        while (sbq.size() > 0) @(negedge clk);
        repeat (20) @(negedge clk);
    endtask

    initial begin : watchdog
        wait (cyc > 20000);
        fails++;
        $display("FAIL watchdog cyc=%0d expected completion", cyc);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin : driver
        repeat (3) @(negedge clk);
        expect_at(0, 1'b1, "R7 during reset");
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        expect_at(60, 1'b1, "R7 after release");
        expect_at(140, 1'b0, "R7 window end");
        drain();

        // R1: ten low samples rejected
        expect_at(8, 1'b0, "R1 glitch");
        expect_at(20, 1'b0, "R1 glitch");
        expect_at(60, 1'b0, "R1 glitch");
        host_low(10);
        drain();

        // R2/R3: eleven low samples qualify, minimum window
        expect_at(2, 1'b0, "R2 before qualify");
        expect_at(20, 1'b1, "R2 qualified");
        expect_at(95, 1'b1, "R3 window running");
        expect_at(140, 1'b0, "R3 window done");
        host_low(11);
        drain();

        // R4: host held low past the window
        expect_at(250, 1'b1, "R4 extended");
        expect_at(301, 1'b1, "R4 at release");
        expect_at(306, 1'b0, "R4 released");
        host_low(300);
        drain();

        // R8: re-assertion restarts the window
        expect_at(140, 1'b1, "R8 restarted");
        expect_at(210, 1'b0, "R8 done");
        host_low(15);
        repeat (45) @(negedge clk);
        host_low(15);
        drain();

        // R6: undervoltage in idle
        expect_at(1, 1'b1, "R6 uv on");
        expect_at(5, 1'b1, "R6 uv held");
        expect_at(11, 1'b0, "R6 uv off");
        uv_req = 1'b1;
        repeat (10) @(negedge clk);
        uv_req = 1'b0;
        drain();

        // R6 with window expiry in the same span
        expect_at(140, 1'b1, "R6 uv past window");
        expect_at(162, 1'b0, "R6 uv drop after window");
        host_low(11);
        repeat (69) @(negedge clk);
        uv_req = 1'b1;
        repeat (80) @(negedge clk);
        uv_req = 1'b0;
        drain();

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule